// File: doc/BRIEF.md
# Multiplexed-Bus Register Access Port

This block is the slave side of a register port on a bus that carries address and data on the same wires. An address strobe marks the address phase and a data strobe marks the data phase. Neither strobe has a fixed phase relation to the peripheral clock. The block passes both strobes, and every bus qualifier with them, through a multi-flop synchronizer. On the synchronized rising edge of the address strobe it captures the register address, the interrupt-acknowledge level and the active-low first chip select. On the synchronized falling edge of the data strobe it turns the access into one write pulse for the register file, or into a read window that drives the file's output back onto the bus.

Consecutive accesses to this block must be spaced by a minimum recovery interval, counted in peripheral clocks between selected data-strobe falls. An access that comes too early is dropped and sets a sticky error flag. A separate clear input resets the flag. Every address-strobe cycle also produces a one-clock tick, which an interrupt-pending update path uses. That path therefore advances only while the host keeps the address strobe toggling.

Top module: `mbus_reg_port`

## Requirements
- R1: On each synchronized rising edge of `as_n`, `reg_addr` takes the low 4 bits of `ad_in` and holds them until the next such edge. The `inta_n` and `cs0_n` levels are captured at the same point.
- R2: A write is accepted when the latched `cs0_n` is 0, `cs1` is 1, `rd_wr` is 0 (0 means write, 1 means read) and the latched `inta_n` is 1 at the synchronized fall of `ds_n`. It gives exactly one one-clock `reg_wr_en` pulse, with `reg_addr` at the latched address and `reg_wr_data` equal to `ad_in` sampled with that fall.
- R3: For an accepted read (`rd_wr` = 1), `ad_oe` is 1 only while the synchronized `ds_n` is low, and `ad_out` equals `reg_rd_data`. Whenever `ad_oe` is 0, `ad_out` is 0. `reg_wr_en` and `ad_oe` are never 1 together.
- R4: A data strobe with `cs1` = 0, or after an address phase that latched `cs0_n` = 1, makes no write pulse and no read window.
- R5: After an address phase that latched `inta_n` = 0, the data strobe makes no register access, and `ad_oe` stays 0.
- R6: A selected data-strobe fall that comes RECOVERY_CLKS (default 4) or more clocks after the previous accepted selected fall is accepted.
- R7: A selected fall that comes sooner than that is suppressed and sets `recov_err`. The flag stays 1 until `recov_clr` is pulsed. A suppressed access does not restart the recovery interval.
- R8: Data-strobe falls that do not select the block neither restart nor extend the recovery interval.
- R9: Every synchronized rising edge of `as_n` gives exactly one one-clock `irq_tick` pulse, whether or not the block is selected.
- R10: Synchronous reset (`rst` = 1) sets `reg_addr` to 0 and clears the recovery counter and `recov_err`. It also drives `reg_wr_en`, `ad_oe` and `irq_tick` to 0. The first selected access after reset is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| as_n | input | 1 | Address strobe, active low, asynchronous |
| ds_n | input | 1 | Data strobe, active low, asynchronous |
| cs0_n | input | 1 | Chip select 0, active low, latched with the address |
| cs1 | input | 1 | Chip select 1, active high, sampled in the data phase |
| rd_wr | input | 1 | Direction: 1 read, 0 write |
| inta_n | input | 1 | Interrupt acknowledge, active low, latched with the address |
| ad_in | input | 8 | Shared address/data bus, inbound |
| ad_out | output | 8 | Read data onto the bus |
| ad_oe | output | 1 | Bus output enable |
| reg_addr | output | 4 | Latched register address |
| reg_wr_en | output | 1 | One-clock register write strobe |
| reg_wr_data | output | 8 | Register write data |
| reg_rd_data | input | 8 | Register file read data |
| irq_tick | output | 1 | One-clock tick per address-strobe cycle |
| recov_clr | input | 1 | Clears the recovery-violation flag |
| recov_err | output | 1 | Sticky recovery-violation flag |

## Verification
A table of complete transactions is applied first. It covers selected writes and reads, writes with the second chip select low, address phases with the first chip select inactive, and interrupt-acknowledge cycles. These tell a real access apart from each way of being deselected, and they show whether read data comes from the address that was actually written. Directed strobe trains then place data-strobe falls 3, 4 and 5 clocks apart, sometimes with a deselected fall in between. These separate an early fall from an exact-limit fall, and they show whether a suppressed or deselected fall wrongly moves the recovery window. A final reset in the middle of an error confirms that the flag and the address clear.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
   typedef enum logic {
      XFER_WRITE = 1'b0,
      XFER_READ  = 1'b1
   } xfer_dir_e;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
   parameter int unsigned   STAGES  = 2,
   parameter int unsigned   W       = 1,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [W-1:0]  d,
   output logic [W-1:0]  q
);
   logic [W-1:0] stg [STAGES];

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("mbus_sync needs at least one stage");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) stg[i] <= RST_VAL;
               else     stg[i] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) stg[i] <= RST_VAL;
               else     stg[i] <= stg[i-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch #(
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              as_rise,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_inta_n,
   input  logic              bus_cs0_n,
   output logic [ADDR_W-1:0] addr,
   output logic              inta_act,
   output logic              cs0_sel
);
   always_ff @(posedge clk) begin
      if (rst) begin
         addr     <= '0;
         inta_act <= 1'b0;
         cs0_sel  <= 1'b0;
      end else if (as_rise) begin
         addr     <= bus_addr;
         inta_act <= ~bus_inta_n;
         cs0_sel  <= ~bus_cs0_n;
      end
   end

   // R1
   addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !as_rise |=> $stable(addr));
endmodule

// File: rtl/mbus_recovery.sv
module mbus_recovery #(
   parameter int unsigned RECOVERY_CLKS = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic req,
   input  logic clr,
   output logic grant,
   output logic err
);
   localparam int unsigned CNT_W = mbus_pkg::cnt_width(RECOVERY_CLKS);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(RECOVERY_CLKS - 1);

   logic [CNT_W-1:0] cnt;
   logic             viol;

   assign grant = req && (cnt == '0);
   assign viol  = req && (cnt != '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else if (grant) begin
         cnt <= LOAD;
      end else if (cnt != '0) begin
         cnt <= cnt - CNT_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (rst)       err <= 1'b0;
      else if (viol) err <= 1'b1;
      else if (clr)  err <= 1'b0;
   end

   // R7
   viol_sets_err_chk: assert property (@(posedge clk) disable iff (rst)
      viol |=> err);
   // R7
   err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (err && !clr) |=> err);
   // R6
   grant_not_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
      (grant && RECOVERY_CLKS > 1) |=> !grant);
endmodule

// File: rtl/mbus_reg_port.sv
module mbus_reg_port #(
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned ADDR_W        = 4,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned RECOVERY_CLKS = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              as_n,
   input  logic              ds_n,
   input  logic              cs0_n,
   input  logic              cs1,
   input  logic              rd_wr,
   input  logic              inta_n,
   input  logic [DATA_W-1:0] ad_in,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              reg_wr_en,
   output logic [DATA_W-1:0] reg_wr_data,
   input  logic [DATA_W-1:0] reg_rd_data,
   output logic              irq_tick,
   input  logic              recov_clr,
   output logic              recov_err
);
   import mbus_pkg::*;

   localparam int unsigned PIPE_W = DATA_W + 4;
   localparam logic [PIPE_W-1:0] PIPE_RST = {{DATA_W{1'b0}}, 4'b1100};

   generate
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (RECOVERY_CLKS < 1) begin : g_chk_rec
         $error("RECOVERY_CLKS must be at least 1");
      end
      if (ADDR_W > DATA_W) begin : g_chk_addr
         $error("ADDR_W must not exceed DATA_W");
      end
   endgenerate

   // strobe synchronizer
   logic as_s, ds_s;
   mbus_sync #(.STAGES(SYNC_STAGES), .W(2), .RST_VAL(2'b11)) i_strobe_sync (
      .clk (clk),
      .rst (rst),
      .d   ({as_n, ds_n}),
      .q   ({as_s, ds_s})
   );

   // qualifier pipe, same depth so it stays aligned with the strobes
   logic [DATA_W-1:0] p_ad;
   logic              p_inta_n, p_cs0_n, p_cs1, p_rd_wr;
   mbus_sync #(.STAGES(SYNC_STAGES), .W(PIPE_W), .RST_VAL(PIPE_RST)) i_qual_pipe (
      .clk (clk),
      .rst (rst),
      .d   ({ad_in, inta_n, cs0_n, cs1, rd_wr}),
      .q   ({p_ad, p_inta_n, p_cs0_n, p_cs1, p_rd_wr})
   );

   // edge detection
   logic as_q, ds_q, as_rise, ds_fall;
   always_ff @(posedge clk) begin
      if (rst) begin
         as_q <= 1'b1;
         ds_q <= 1'b1;
      end else begin
         as_q <= as_s;
         ds_q <= ds_s;
      end
   end
   assign as_rise = as_s & ~as_q;
   assign ds_fall = ~ds_s & ds_q;

   // address phase
   logic inta_act, cs0_sel;
   mbus_addr_latch #(.ADDR_W(ADDR_W)) i_addr_latch (
      .clk        (clk),
      .rst        (rst),
      .as_rise    (as_rise),
      .bus_addr   (p_ad[ADDR_W-1:0]),
      .bus_inta_n (p_inta_n),
      .bus_cs0_n  (p_cs0_n),
      .addr       (reg_addr),
      .inta_act   (inta_act),
      .cs0_sel    (cs0_sel)
   );

   // data phase qualification and recovery
   logic sel_req, grant;
   assign sel_req = ds_fall & cs0_sel & p_cs1 & ~inta_act;

   mbus_recovery #(.RECOVERY_CLKS(RECOVERY_CLKS)) i_recovery (
      .clk   (clk),
      .rst   (rst),
      .req   (sel_req),
      .clr   (recov_clr),
      .grant (grant),
      .err   (recov_err)
   );

   xfer_dir_e dir;
   assign dir = xfer_dir_e'(p_rd_wr);

   logic rd_active;
   always_ff @(posedge clk) begin
      if (rst) begin
         reg_wr_en   <= 1'b0;
         reg_wr_data <= '0;
         rd_active   <= 1'b0;
         irq_tick    <= 1'b0;
      end else begin
         reg_wr_en <= grant && (dir == XFER_WRITE);
         if (grant && (dir == XFER_WRITE)) reg_wr_data <= p_ad;
         if (grant && (dir == XFER_READ)) rd_active <= 1'b1;
         else if (ds_s)                   rd_active <= 1'b0;
         irq_tick <= as_rise;
      end
   end

   assign ad_oe  = rd_active;
   assign ad_out = rd_active ? reg_rd_data : '0;

   // R2
   wr_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      reg_wr_en |=> !reg_wr_en);
   // R3
   oe_inside_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      ad_oe |-> $past(!ds_s));
   // R3
   wr_oe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
      !(reg_wr_en && ad_oe));
   // R9
   tick_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      irq_tick |=> !irq_tick);
   // R5
   inta_no_access_chk: assert property (@(posedge clk) disable iff (rst)
      (ds_fall && inta_act) |=> !(reg_wr_en || $rose(ad_oe)));
endmodule

// File: tb/test_mbus_reg_port.sv
module test_mbus_reg_port;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       as_n = 1'b1, ds_n = 1'b1, cs0_n = 1'b1, cs1 = 1'b0;
   logic       rd_wr = 1'b0, inta_n = 1'b1, recov_clr = 1'b0;
   logic [7:0] ad_in = 8'h00;
   logic [7:0] ad_out, reg_wr_data, reg_rd_data;
   logic [3:0] reg_addr;
   logic       ad_oe, reg_wr_en, irq_tick, recov_err;

   always #5 clk = ~clk;

   mbus_reg_port i_mbus_reg_port (
      .clk(clk), .rst(rst), .as_n(as_n), .ds_n(ds_n), .cs0_n(cs0_n), .cs1(cs1),
      .rd_wr(rd_wr), .inta_n(inta_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
      .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
      .reg_rd_data(reg_rd_data), .irq_tick(irq_tick), .recov_clr(recov_clr),
      .recov_err(recov_err)
   );

   // bench register file, written through the design's write port
   logic [7:0] mem [16];
   logic [7:0] exp_mem [16];
   assign reg_rd_data = mem[reg_addr];

   int n_checks = 0, n_fail = 0;
   int wr_cnt = 0, tick_cnt = 0, oe_cnt = 0;
   logic [3:0] last_wa = '0;
   logic [7:0] last_wd = '0, last_out = '0;
   logic out_leak = 1'b0;

   always @(negedge clk) begin
      if (!rst) begin
         if (reg_wr_en) begin
            wr_cnt++;
            last_wa = reg_addr;
            last_wd = reg_wr_data;
            mem[reg_addr] = reg_wr_data;
         end
         if (irq_tick) tick_cnt++;
         if (ad_oe) begin
            oe_cnt++;
            last_out = ad_out;
         end else if (ad_out != 8'h00) begin
            out_leak = 1'b1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clr_counts();
      wr_cnt = 0; tick_cnt = 0; oe_cnt = 0; out_leak = 1'b0;
   endtask

   task automatic addr_phase(input logic [3:0] a, input logic c0n, input logic ian);
      @(negedge clk);
      as_n = 1'b0; ad_in = {4'h0, a}; cs0_n = c0n; inta_n = ian;
      tick(3);
      as_n = 1'b1;
      tick(4);
   endtask

   typedef struct packed {
      logic [3:0] a;
      logic [7:0] d;
      logic       rd;
      logic       c0n;
      logic       c1;
      logic       ian;
      logic       acc;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      '{4'h3, 8'hA5, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
      '{4'hC, 8'h3C, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
      '{4'h3, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
      '{4'h5, 8'h77, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
      '{4'h5, 8'h88, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
      '{4'h5, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
      '{4'h5, 8'h11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
      '{4'hC, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
      '{4'hF, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
      '{4'h0, 8'h01, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
      '{4'hF, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
      '{4'h5, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
      '{4'hC, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}
   };

   // one data-strobe fall, low for 'low' cycles then high for 'high' cycles
   task automatic ds_fall(input logic [7:0] d, input logic sel1, input int low, input int high);
      ad_in = d; cs1 = sel1; ds_n = 1'b0;
      tick(low);
      ds_n = 1'b1;
      tick(high);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) begin
         mem[i] = 8'h00;
         exp_mem[i] = 8'h00;
      end
      tick(5);
      // R10 reset state
      chk(reg_addr == 4'h0 && !reg_wr_en && !ad_oe && !irq_tick && !recov_err,
          "R10 reset outputs", {reg_addr, reg_wr_en, ad_oe, irq_tick, recov_err}, 0);
      rst = 1'b0;
      tick(3);

      // vector table
      for (int v = 0; v < NV; v++) begin
         clr_counts();
         addr_phase(VECS[v].a, VECS[v].c0n, VECS[v].ian);
         rd_wr = VECS[v].rd;
         ds_fall(VECS[v].rd ? 8'h00 : VECS[v].d, VECS[v].c1, 6, 8);
         cs1 = 1'b0;
         ad_in = 8'h00;
         // R9
         chk(tick_cnt == 1, "R9 tick per address strobe", tick_cnt, 1);
         // R1
         chk(reg_addr == VECS[v].a, "R1 latched address", reg_addr, VECS[v].a);
         if (!VECS[v].rd) begin
            // R2 / R4 / R5 (R10 for the first vector)
            chk(wr_cnt == (VECS[v].acc ? 1 : 0), "R2 R4 R5 write count", wr_cnt, VECS[v].acc);
            if (VECS[v].acc) begin
               exp_mem[VECS[v].a] = VECS[v].d;
               chk(last_wa == VECS[v].a && last_wd == VECS[v].d, "R2 write addr/data",
                   {last_wa, last_wd}, {VECS[v].a, VECS[v].d});
            end
         end else begin
            // R3 / R4 / R5
            chk((oe_cnt > 0) == VECS[v].acc, "R3 R4 R5 read window", oe_cnt, VECS[v].acc);
            chk(wr_cnt == 0, "R3 no write on read", wr_cnt, 0);
            if (VECS[v].acc)
               chk(last_out == exp_mem[VECS[v].a], "R3 read data", last_out, exp_mem[VECS[v].a]);
         end
         chk(!ad_oe && !out_leak, "R3 bus idle after strobe", {ad_oe, out_leak}, 0);
      end

      // R7: falls at 0, 3 and 5 (the 3 is early, the 5 is 5 after the accepted one)
      clr_counts();
      addr_phase(4'h2, 1'b0, 1'b1);
      rd_wr = 1'b0;
      ds_fall(8'h10, 1'b1, 1, 2);
      ds_fall(8'h20, 1'b1, 1, 1);
      ds_fall(8'h30, 1'b1, 1, 10);
      cs1 = 1'b0;
      chk(wr_cnt == 2, "R7 early access suppressed", wr_cnt, 2);
      chk(last_wd == 8'h30, "R7 suppressed access keeps window", last_wd, 8'h30);
      chk(recov_err == 1'b1, "R7 error flag set", recov_err, 1);
      tick(10);
      chk(recov_err == 1'b1, "R7 error flag sticky", recov_err, 1);
      recov_clr = 1'b1;
      tick(1);
      recov_clr = 1'b0;
      tick(2);
      chk(recov_err == 1'b0, "R7 error flag cleared", recov_err, 0);

      // R6: falls exactly 4 apart
      clr_counts();
      ds_fall(8'h40, 1'b1, 1, 3);
      ds_fall(8'h50, 1'b1, 1, 10);
      cs1 = 1'b0;
      chk(wr_cnt == 2 && last_wd == 8'h50, "R6 access at recovery limit", {wr_cnt[7:0], last_wd}, 16'h0250);
      chk(recov_err == 1'b0, "R6 no error at limit", recov_err, 0);

      // R8: deselected fall in the middle of the window
      clr_counts();
      ds_fall(8'h60, 1'b1, 1, 1);
      ds_fall(8'h66, 1'b0, 1, 1);
      ds_fall(8'h70, 1'b1, 1, 10);
      cs1 = 1'b0;
      chk(wr_cnt == 2 && last_wd == 8'h70, "R8 deselected fall ignored by timer",
          {wr_cnt[7:0], last_wd}, 16'h0270);
      chk(recov_err == 1'b0, "R8 no error", recov_err, 0);

      // R10: reset in the middle of an error
      ds_fall(8'h80, 1'b1, 1, 1);
      ds_fall(8'h81, 1'b1, 1, 6);
      cs1 = 1'b0;
      chk(recov_err == 1'b1, "R7 error before reset", recov_err, 1);
      rst = 1'b1;
      tick(2);
      rst = 1'b0;
      tick(1);
      chk(reg_addr == 4'h0 && !recov_err && !reg_wr_en && !ad_oe,
          "R10 reset clears address and flag", {reg_addr, recov_err}, 0);
      clr_counts();
      addr_phase(4'h9, 1'b0, 1'b1);
      rd_wr = 1'b0;
      ds_fall(8'h5A, 1'b1, 1, 8);
      cs1 = 1'b0;
      chk(wr_cnt == 1 && last_wa == 4'h9 && last_wd == 8'h5A, "R10 first access after reset",
          {wr_cnt[3:0], last_wa, last_wd}, 16'h195A);

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule